// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading descriptors from a three-level table tree in memory. A walk starts from one of two root pointers, picked by whether the access is privileged. It reads a root descriptor, then a pointer descriptor, then a page descriptor. If the page descriptor is an indirect one, it reads one more descriptor. All reads go out one at a time over a request/valid memory port.

Along the way the walker checks each descriptor's type. It gathers write protection from every level and checks privilege against the page. It also sets the used and modified status bits by writing updated descriptors back to memory. When the walk ends it gives a one-cycle done pulse with the physical address, the page attributes and a fault code. When translation is switched off, the logical address passes straight through.

Top module: `ptw_walker`

## Requirements
- R1: With `xlat_en_i` low, an accepted request gives `done_o` in the next cycle. In that cycle `pa_o` equals the logical address, the fault code is 0, every attribute output is 0, and no memory access is made.
- R2: The walker reads descriptors at these addresses:
  - root: `{root[31:9], la[31:25], 2'b00}`, where the root is `super_root_i` when `super_i` is 1 and `user_root_i` otherwise;
  - pointer: `{d1[31:9], la[24:18], 2'b00}`;
  - page, 4K pages (`page8k_i`=0): `{d2[31:8], la[17:12], 2'b00}`;
  - page, 8K pages (`page8k_i`=1): `{d2[31:7], la[17:13], 2'b00}`.
- R3: A root or pointer descriptor whose bit 1 is 0 (type 00 or 01) ends the walk with fault code 1 (invalid). Type 10 or 11 lets the walk go on.
- R4: A page descriptor of type 00 gives fault 1, and type 01 or 11 is resident. Type 10 is indirect: the walker then reads the final descriptor at `{d[31:2], 2'b00}`. If that final descriptor is type 10 or 00, the fault is 1.
- R5: On success, `pa_o` depends on page size:
  - 4K: `{pd[31:12], la[11:0]}`;
  - 8K: `{pd[31:13], la[12:0]}`.
  The attribute outputs come from the final page descriptor: `cmode_o`=bits 6:5 (00 write-through, 01 copy-back, 10 non-cacheable serialized, 11 non-cacheable), `super_only_o`=bit 7, `upa_o`=bits 9:8, `global_o`=bit 10.
- R6: Bit 2 of the root, pointer or page descriptor marks write protection. A write access with any of these set ends with fault code 2. A read of the same page succeeds, with `wprot_o`=1.
- R7: A user access (`super_i`=0) to a page whose bit 7 is set gives fault code 3. This fault takes priority over fault code 2. A privileged access to the same page succeeds.
- R8: A root or pointer descriptor with bit 3 clear is written back with bit 3 set, before the next read. On a successful walk, the final page descriptor is written back with bit 3 set, and with bit 4 also set for a write, but only if this changes it. A faulted page is not written.
- R9: A response with `mem_err_i` set ends the walk with fault code 4.
- R10: `ready_o` is low from the cycle after acceptance until the done cycle. A request raised while busy is ignored. `done_o` is a single-cycle pulse for each accepted request.
- R11: `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady until a cycle with `mem_valid_i` high completes the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable |
| page8k_i | input | 1 | Page size: 0 = 4K, 1 = 8K |
| user_root_i | input | 32 | Root table base for user accesses |
| super_root_i | input | 32 | Root table base for privileged accesses |
| req_i | input | 1 | Translation request |
| la_i | input | 32 | Logical address |
| write_i | input | 1 | Access is a write |
| super_i | input | 1 | Access is privileged |
| ready_o | output | 1 | Walker idle, request accepted |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Descriptor address |
| mem_wdata_o | output | 32 | Descriptor write-back data |
| mem_valid_i | input | 1 | Memory access complete |
| mem_err_i | input | 1 | Bus error on the completing access |
| mem_rdata_i | input | 32 | Descriptor read data |
| done_o | output | 1 | Walk finished, results valid |
| pa_o | output | 32 | Physical address |
| fault_o | output | 3 | 0 none, 1 invalid, 2 write-protect, 3 privilege, 4 bus error |
| cmode_o | output | 2 | Cache mode |
| super_only_o | output | 1 | Page is privileged-only |
| upa_o | output | 2 | User page attributes |
| global_o | output | 1 | Global page |
| wprot_o | output | 1 | Write protection seen along the walk |

## Verification
The assertions assume that the memory side:
- raises `mem_valid_i` only while `mem_req_o` is high, for exactly one cycle per access;
- raises `mem_err_i` only together with `mem_valid_i`.

They also assume the request inputs are sampled only while `ready_o` is high. The bench's responder keeps to this. It counts a latency of one to three cycles from the first sight of a request, pulses valid once, and drops it in the next cycle. Bus errors are tied to one chosen address. A request raised mid-walk is used on purpose, to show it is ignored rather than to break these assumptions.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_INVALID = 3'd1,
    FLT_WPROT   = 3'd2,
    FLT_PRIV    = 3'd3,
    FLT_BUS     = 3'd4
  } fault_e;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_UPD, ST_FIN} walk_st_e;

  // descriptor bit positions
  localparam int unsigned B_WP   = 2;
  localparam int unsigned B_USED = 3;
  localparam int unsigned B_MOD  = 4;
  localparam int unsigned B_CM   = 5;
  localparam int unsigned B_SUP  = 7;
  localparam int unsigned B_UPA  = 8;
  localparam int unsigned B_GLB  = 10;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int unsigned AW    = 32,
  parameter int unsigned RI_W  = 7,
  parameter int unsigned PI_W  = 7,
  parameter int unsigned OFF_W = 12
) (
  input  logic [AW-1:0] la_i,
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    lvl_i,
  input  logic          page8k_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned RI_LSB = AW - RI_W;
  localparam int unsigned PI_LSB = RI_LSB - PI_W;
  localparam int unsigned PG4_W  = PI_LSB - OFF_W;
  localparam int unsigned PG8_W  = PG4_W - 1;
  localparam int unsigned RT_AL  = RI_W + 2;
  localparam int unsigned PT_AL  = PI_W + 2;
  localparam int unsigned G4_AL  = PG4_W + 2;
  localparam int unsigned G8_AL  = PG8_W + 2;

  logic unused_bits;
  assign unused_bits = ^{base_i[1:0], la_i[OFF_W-1:0]};

  always_comb begin
    unique case (lvl_i)
      2'd0: addr_o = {base_i[AW-1:RT_AL], la_i[AW-1:RI_LSB], 2'b00};
      2'd1: addr_o = {base_i[AW-1:PT_AL], la_i[RI_LSB-1:PI_LSB], 2'b00};
      2'd2: addr_o = page8k_i ? {base_i[AW-1:G8_AL], la_i[PI_LSB-1:OFF_W+1], 2'b00}
                              : {base_i[AW-1:G4_AL], la_i[PI_LSB-1:OFF_W], 2'b00};
      default: addr_o = {base_i[AW-1:2], 2'b00};   // indirect target
    endcase
  end
endmodule

// File: rtl/ptw_desc.sv
module ptw_desc
  import ptw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] desc_i,
  input  logic          page_lvl_i,
  input  logic          ind_lvl_i,
  input  logic          set_mod_i,
  output logic          valid_o,
  output logic          indirect_o,
  output logic          dirty_o,
  output logic [AW-1:0] upd_o
);
  logic [1:0] dt;
  assign dt = desc_i[1:0];

  always_comb begin
    if (!page_lvl_i) begin
      valid_o    = dt[1];
      indirect_o = 1'b0;
    end else begin
      indirect_o = (dt == 2'b10) && !ind_lvl_i;
      valid_o    = (dt != 2'b00) && !((dt == 2'b10) && ind_lvl_i);
    end
    upd_o         = desc_i;
    upd_o[B_USED] = 1'b1;
    if (page_lvl_i && set_mod_i) upd_o[B_MOD] = 1'b1;
    dirty_o = (upd_o != desc_i);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned RI_W  = 7,
  parameter int unsigned PI_W  = 7,
  parameter int unsigned OFF_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xlat_en_i,
  input  logic          page8k_i,
  input  logic [AW-1:0] user_root_i,
  input  logic [AW-1:0] super_root_i,
  input  logic          req_i,
  input  logic [AW-1:0] la_i,
  input  logic          write_i,
  input  logic          super_i,
  output logic          ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic          mem_valid_i,
  input  logic          mem_err_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [AW-1:0] pa_o,
  output logic [2:0]    fault_o,
  output logic [1:0]    cmode_o,
  output logic          super_only_o,
  output logic [1:0]    upa_o,
  output logic          global_o,
  output logic          wprot_o
);
  walk_st_e           st;
  fault_e             flt_q;
  logic [1:0]         lvl;
  logic [AW-1:0]      la_q, base_q, addr_q, wdata_q;
  logic [AW-1:OFF_W]  frame_q;
  logic [1:0]         cm_q, upa_q;
  logic               so_q, gl_q, wr_q, sup_q, p8k_q, wp_q, byp_q;

  logic [1:0]    au_lvl;
  logic [AW-1:0] au_base, au_la, au_addr, upd;
  logic          au_p8k, dv, dind, dirty, wp_tot, priv;

  always_comb begin
    if (st == ST_IDLE) begin
      au_lvl  = 2'd0;
      au_base = super_i ? super_root_i : user_root_i;
      au_la   = la_i;
      au_p8k  = page8k_i;
    end else begin
      au_lvl  = lvl + 2'd1;
      au_base = (st == ST_READ) ? mem_rdata_i : base_q;
      au_la   = la_q;
      au_p8k  = p8k_q;
    end
  end

  ptw_addr #(.AW(AW), .RI_W(RI_W), .PI_W(PI_W), .OFF_W(OFF_W)) u_addr (
    .la_i(au_la), .base_i(au_base), .lvl_i(au_lvl), .page8k_i(au_p8k), .addr_o(au_addr)
  );

  ptw_desc #(.AW(AW)) u_desc (
    .desc_i(mem_rdata_i), .page_lvl_i(lvl[1]), .ind_lvl_i(lvl == 2'd3), .set_mod_i(wr_q),
    .valid_o(dv), .indirect_o(dind), .dirty_o(dirty), .upd_o(upd)
  );

  assign wp_tot = wp_q | mem_rdata_i[B_WP];
  assign priv   = !sup_q && mem_rdata_i[B_SUP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; flt_q <= FLT_NONE; lvl <= 2'd0;
      la_q <= '0; base_q <= '0; addr_q <= '0; wdata_q <= '0; frame_q <= '0;
      cm_q <= '0; upa_q <= '0; so_q <= 1'b0; gl_q <= 1'b0;
      wr_q <= 1'b0; sup_q <= 1'b0; p8k_q <= 1'b0; wp_q <= 1'b0; byp_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_i) begin
          la_q <= la_i; wr_q <= write_i; sup_q <= super_i; p8k_q <= page8k_i;
          wp_q <= 1'b0; byp_q <= !xlat_en_i; lvl <= 2'd0; flt_q <= FLT_NONE;
          if (xlat_en_i) begin
            addr_q <= au_addr;
            st     <= ST_READ;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_READ: if (mem_valid_i) begin
          if (mem_err_i) begin
            flt_q <= FLT_BUS; st <= ST_FIN;
          end else if (!dv) begin
            flt_q <= FLT_INVALID; st <= ST_FIN;
          end else if (!lvl[1]) begin
            wp_q   <= wp_tot;
            base_q <= mem_rdata_i;
            if (dirty) begin
              wdata_q <= upd; st <= ST_UPD;
            end else begin
              addr_q <= au_addr; lvl <= lvl + 2'd1;
            end
          end else if (dind) begin
            addr_q <= au_addr; lvl <= 2'd3;
          end else begin
            wp_q    <= wp_tot;
            frame_q <= mem_rdata_i[AW-1:OFF_W];
            cm_q    <= mem_rdata_i[B_CM+1:B_CM];
            so_q    <= mem_rdata_i[B_SUP];
            upa_q   <= mem_rdata_i[B_UPA+1:B_UPA];
            gl_q    <= mem_rdata_i[B_GLB];
            if (priv) begin
              flt_q <= FLT_PRIV; st <= ST_FIN;
            end else if (wr_q && wp_tot) begin
              flt_q <= FLT_WPROT; st <= ST_FIN;
            end else if (dirty) begin
              wdata_q <= upd; st <= ST_UPD;
            end else begin
              st <= ST_FIN;
            end
          end
        end
        ST_UPD: if (mem_valid_i) begin
          if (mem_err_i) begin
            flt_q <= FLT_BUS; st <= ST_FIN;
          end else if (!lvl[1]) begin
            addr_q <= au_addr; lvl <= lvl + 2'd1; st <= ST_READ;
          end else begin
            st <= ST_FIN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic          ok;
  logic [AW-1:0] phys;
  assign ok   = (flt_q == FLT_NONE) && !byp_q;
  assign phys = p8k_q ? {frame_q[AW-1:OFF_W+1], la_q[OFF_W:0]}
                      : {frame_q, la_q[OFF_W-1:0]};

  assign ready_o      = (st == ST_IDLE);
  assign done_o       = (st == ST_FIN);
  assign mem_req_o    = (st == ST_READ) || (st == ST_UPD);
  assign mem_we_o     = (st == ST_UPD);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
  assign fault_o      = flt_q;
  assign pa_o         = byp_q ? la_q : (ok ? phys : '0);
  assign cmode_o      = ok ? cm_q : 2'b00;
  assign super_only_o = ok & so_q;
  assign upa_o        = ok ? upa_q : 2'b00;
  assign global_o     = ok & gl_q;
  assign wprot_o      = ok & wp_q;

  assert_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i && !xlat_en_i |=> done_o && !mem_req_o && fault_o == 3'd0);

  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i && xlat_en_i |=> !ready_o && mem_req_o && !mem_we_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_wb_used_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[B_USED]);
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        xlat_en_i = 1'b0, page8k_i = 1'b0, req_i = 1'b0, write_i = 1'b0, super_i = 1'b0;
  logic [31:0] user_root_i = 32'h0001_0000, super_root_i = 32'h0002_0000, la_i = '0;
  logic        mem_valid_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        ready_o, mem_req_o, mem_we_o, done_o, super_only_o, global_o, wprot_o;
  logic [31:0] mem_addr_o, mem_wdata_o, pa_o;
  logic [2:0]  fault_o;
  logic [1:0]  cmode_o, upa_o;

  ptw_walker i_ptw_walker (.*);

  always #5 clk_i = ~clk_i;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_mem [logic [31:0]];
  int n_chk = 0, n_bad = 0, req_cnt = 0, lat = 1;
  bit err_on = 0;
  logic [31:0] err_addr = '0;

  localparam logic [31:0] UR = 32'h0001_0000, SR = 32'h0002_0000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [31:0] a, logic [31:0] d);
    mem[a] = d; exp_mem[a] = d;
  endtask

  function automatic logic [31:0] rdm(logic [31:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] pdesc(logic [31:0] frame, logic [1:0] cm, bit so,
      logic [1:0] upa, bit gl, bit md, bit used, bit wp, logic [1:0] typ);
    return frame | ({21'd0, gl, upa, so, cm, md, used, wp, typ});
  endfunction

  // memory responder
  initial begin
    int cnt = 0;
    logic [31:0] a0 = '0;
    forever begin
      @(negedge clk_i);
      if (mem_valid_i) begin
        mem_valid_i = 1'b0; mem_err_i = 1'b0; cnt = 0;
      end else if (mem_req_o) begin
        if (cnt == 0) a0 = mem_addr_o;
        cnt++;
        if (cnt >= lat) begin
          chk("R11", mem_addr_o, a0, "address held until valid");
          mem_valid_i = 1'b1;
          mem_err_i   = err_on && (mem_addr_o == err_addr);
          req_cnt++;
          if (mem_we_o) begin
            if (!mem_err_i) mem[mem_addr_o] = mem_wdata_o;
          end else begin
            mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
          end
        end
      end
    end
  end

  task automatic ref_walk(input logic [31:0] la, input bit wr, sup, en, p8k,
      output logic [2:0] f, output logic [31:0] pa, output logic [1:0] cm, output logic so,
      output logic [1:0] upa, output logic gl, output logic wp);
    logic [31:0] a, d, nd, root;
    bit wpa;
    f = 0; pa = 0; cm = 0; so = 0; upa = 0; gl = 0; wp = 0; wpa = 0;
    if (!en) begin pa = la; return; end
    root = sup ? SR : UR;
    a = {root[31:9], la[31:25], 2'b00};
    for (int l = 0; l < 2; l++) begin
      if (err_on && a == err_addr) begin f = 4; return; end
      d = rdm(a);
      if (!d[1]) begin f = 1; return; end
      wpa |= d[2];
      if (!d[3]) exp_mem[a] = d | 32'h8;
      if (l == 0) a = {d[31:9], la[24:18], 2'b00};
      else a = p8k ? {d[31:7], la[17:13], 2'b00} : {d[31:8], la[17:12], 2'b00};
    end
    if (err_on && a == err_addr) begin f = 4; return; end
    d = rdm(a);
    if (d[1:0] == 2'b10) begin
      a = {d[31:2], 2'b00};
      if (err_on && a == err_addr) begin f = 4; return; end
      d = rdm(a);
      if (d[1:0] == 2'b10) begin f = 1; return; end
    end
    if (d[1:0] == 2'b00) begin f = 1; return; end
    if (!sup && d[7]) begin f = 3; return; end
    if (wr && (wpa || d[2])) begin f = 2; return; end
    nd = d | 32'h8 | (wr ? 32'h10 : 32'h0);
    if (nd != d) exp_mem[a] = nd;
    pa  = p8k ? {d[31:13], la[12:0]} : {d[31:12], la[11:0]};
    cm  = d[6:5]; so = d[7]; upa = d[9:8]; gl = d[10]; wp = wpa | d[2];
  endtask

  task automatic walk(string tag, logic [31:0] la, bit wr, bit sup, bit en, bit p8k, bit poke);
    logic [2:0] f; logic [31:0] pa; logic [1:0] cm, upa; logic so, gl, wp;
    int cyc = 0, rc0 = req_cnt;
    bit busy_bad = 0, mem_bad = 0;
    ref_walk(la, wr, sup, en, p8k, f, pa, cm, so, upa, gl, wp);
    @(negedge clk_i);
    req_i = 1; la_i = la; write_i = wr; super_i = sup; xlat_en_i = en; page8k_i = p8k;
    @(negedge clk_i);
    req_i = 0;
    while (!done_o && cyc < 200) begin
      if (ready_o !== 1'b0) busy_bad = 1;
      if (poke && cyc == 1) begin req_i = 1; la_i = ~la; write_i = 1; end
      if (poke && cyc == 2) begin req_i = 0; la_i = la; end
      @(negedge clk_i);
      cyc++;
    end
    req_i = 0;
    chk("R10", {31'd0, done_o}, 32'd1, {tag, " done reached"});
    chk("R10", {31'd0, busy_bad}, 32'd0, {tag, " ready low while busy"});
    if (!en) begin
      chk("R1", cyc, 0, {tag, " bypass latency"});
      chk("R1", req_cnt - rc0, 0, {tag, " bypass memory accesses"});
    end
    chk(tag, {29'd0, fault_o}, {29'd0, f}, "fault code");
    chk(tag, pa_o, pa, "physical address");
    chk(tag, {30'd0, cmode_o}, {30'd0, cm}, "cache mode");
    chk(tag, {30'd0, upa_o}, {30'd0, upa}, "user attrs");
    chk(tag, {29'd0, super_only_o, global_o, wprot_o}, {29'd0, so, gl, wp}, "flags");
    @(negedge clk_i);
    chk("R10", {31'd0, done_o}, 32'd0, {tag, " done single pulse"});
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        chk("R10", {30'd0, done_o, ready_o}, 32'd1, {tag, " no second walk"});
        @(negedge clk_i);
      end
    end
    foreach (exp_mem[k]) if (!mem.exists(k) || mem[k] !== exp_mem[k]) mem_bad = 1;
    if (mem.size() != exp_mem.size()) mem_bad = 1;
    chk("R8", {31'd0, mem_bad}, 32'd0, {tag, " memory image"});
  endtask

  task automatic build(logic [31:0] root, logic [31:0] t2, logic [31:0] t3, logic [31:0] la,
      bit p8k, logic [3:0] f1, logic [3:0] f2, logic [31:0] pd);
    put({root[31:9], la[31:25], 2'b00}, t2 | {28'd0, f1});
    put({t2[31:9], la[24:18], 2'b00}, t3 | {28'd0, f2});
    put(p8k ? {t3[31:7], la[17:13], 2'b00} : {t3[31:8], la[17:12], 2'b00}, pd);
  endtask

  task automatic clr();
    mem.delete(); exp_mem.delete(); err_on = 0;
  endtask

  localparam logic [31:0] LA1 = 32'h1234_5678, LA2 = 32'h8765_4321;
  localparam logic [31:0] T2 = 32'h0003_0000, T3 = 32'h0004_0000, IND = 32'h0007_0010;
  localparam logic [31:0] PF = 32'h00AB_C000;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R10", {29'd0, ready_o, done_o, mem_req_o}, 32'b100, "reset state");

    walk("R1", 32'hDEAD_BEEF, 0, 0, 0, 0, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1010, pdesc(PF, 2'b01, 0, 2'b10, 1, 0, 1, 0, 2'b01));
    walk("R2", LA1, 0, 0, 1, 0, 0);
    walk("R5", LA1, 0, 0, 1, 0, 0);

    clr(); lat = 2;
    build(UR, T2, T3, LA1, 0, 4'b0010, 4'b0011, pdesc(PF, 2'b00, 0, 2'b00, 0, 0, 0, 0, 2'b11));
    walk("R8", LA1, 1, 0, 1, 0, 0);

    clr(); lat = 1;
    build(SR, 32'h0005_0000, 32'h0006_0080, LA2, 1, 4'b1011, 4'b0010,
          pdesc(32'h0123_6000, 2'b10, 1, 2'b01, 0, 1, 1, 0, 2'b01));
    walk("R2", LA2, 0, 1, 1, 1, 0);
    walk("R5", LA2, 1, 1, 1, 1, 0);
    walk("R7", LA2, 0, 0, 1, 1, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1001, 4'b1010, pdesc(PF, 0, 0, 0, 0, 0, 1, 0, 2'b01));
    walk("R3", LA1, 0, 0, 1, 0, 0);
    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1000, pdesc(PF, 0, 0, 0, 0, 0, 1, 0, 2'b01));
    walk("R3", LA1, 0, 0, 1, 0, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1010, pdesc(PF, 0, 0, 0, 0, 0, 1, 0, 2'b00));
    walk("R4", LA1, 0, 0, 1, 0, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1010, IND | 32'h2);
    put(IND, pdesc(32'h0055_5000, 2'b11, 0, 2'b11, 1, 0, 0, 0, 2'b01));
    walk("R4", LA1, 1, 0, 1, 0, 0);
    put(IND, 32'h0007_0020 | 32'h2);
    walk("R4", LA1, 0, 0, 1, 0, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1110, pdesc(PF, 0, 0, 0, 0, 0, 1, 0, 2'b01));
    walk("R6", LA1, 1, 0, 1, 0, 0);
    walk("R6", LA1, 0, 0, 1, 0, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1010, pdesc(PF, 0, 1, 0, 0, 0, 1, 1, 2'b01));
    walk("R7", LA1, 0, 0, 1, 0, 0);
    walk("R7", LA1, 1, 0, 1, 0, 0);

    clr(); build(UR, T2, T3, LA1, 0, 4'b1010, 4'b1010, pdesc(PF, 0, 0, 0, 0, 0, 1, 0, 2'b01));
    err_on = 1; err_addr = {T3[31:8], LA1[17:12], 2'b00};
    walk("R9", LA1, 0, 0, 1, 0, 0);
    err_addr = {SR[31:9], LA1[31:25], 2'b00};
    walk("R9", LA1, 0, 1, 1, 0, 0);

    clr(); lat = 3;
    build(UR, T2, T3, LA1, 0, 4'b0010, 4'b1010, pdesc(PF, 2'b01, 0, 0, 0, 0, 1, 0, 2'b01));
    walk("R10", LA1, 0, 0, 1, 0, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule